// File: doc/BRIEF.md
# Six-Channel Programmable Countdown Timer Bank

This block holds a set of independent down-counters behind a small memory-mapped register port with one write strobe, one read strobe, a byte address and 32-bit data. Each channel has a control word, a reload value and a live count that software can read. A channel advances only on pulses from one of four single-cycle source enables, which a power-of-two prescaler divides further. When an enabled channel is at zero on a prescaled tick, it has expired. It then raises a sticky status bit, and either reloads and keeps running (periodic) or stops and clears its own enable bit (one-shot).

A shared interrupt-enable register and a shared write-one-to-clear status register produce one interrupt line per channel. Software sets up a channel by writing its reload value and then a control word, with the reload bit set to preload the counter. It services an interrupt by writing a one to the status bit.

Top module: `tmr_bank`

## Requirements
- R1: After reset the interrupt-enable, status, reload and count registers read zero, every channel's control reads 0x04 (source 1, prescaler exponent 0, disabled, periodic), and all irq lines are low.
- R2: Byte offset 0x00 is interrupt enable and 0x04 is status. Channel c (0 to 5) occupies a block at 0x10*(c+1), with control at +0x0, reload value at +0x4 and count at +0x8. Read data appears on rdata in the cycle after rd_en.
- R3: Undefined offsets read zero, and writes to them change nothing. These include 0x08, channel blocks past the last channel, sub-offset +0xC, unaligned addresses and any address with bits above bit 7 set. The count register is read-only.
- R4: The control bits are: enable at bit 0, reload at bit 1, source select at bits [3:2], prescaler exponent at bits [6:4] and one-shot mode at bit 7. A control write with bit 1 set copies the reload value into the count in that same cycle.
- R5: A running channel advances only on pulses of the source_tick bit chosen by its source select. Pulses on other sources have no effect.
- R6: With exponent n, the count steps once per 2^n selected pulses, and a control write restarts that division from zero. A control write in the same cycle as a tick takes priority over the tick.
- R7: A running channel at count zero on a prescaled tick expires and sets its status bit. In periodic mode (bit 7 = 0) it loads the reload value in that same step.
- R8: In one-shot mode (bit 7 = 1) expiry clears control bit 0, which reads back as cleared. The count stays at zero and no further expiry follows.
- R9: irq[c] is high exactly when status bit c and interrupt-enable bit c are both set.
- R10: Writing status clears each bit written as one and leaves the others. An expiry in the same cycle as a clear of its bit leaves that bit set.
- R11: A channel whose enable bit is clear holds its count whatever pulses arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (10) | Byte address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid the cycle after rd_en |
| src_tick | input | NUM_SRC (4) | Single-cycle enable pulses of the clock sources |
| irq | output | NUM_CH (6) | Per-channel interrupt lines |

## Verification
The bench aims at the expiry instant. It checks that a periodic channel reloads on the tick that finds zero rather than one tick later, which an off-by-one design would do by stretching each period. In one-shot mode it reads the control word back after expiry, so a design that stops the counter but forgets to clear bit 0 is caught. It drives a status clear in the same cycle as an expiry, which exposes a design that lets the clear win and loses the event. It also steps a divide-by-four channel across a control write that does not reload, so a prescaler that keeps its old phase decrements early. Finally, it issues pulses on unselected sources and writes to the count register and to undefined offsets, then reads the state those accesses could have corrupted.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

   // field widths fixed by the control-word layout
   localparam int SRC_W = 2;
   localparam int PRE_W = 3;

   // control word: bit7 mode, [6:4] prescale exponent, [3:2] source, bit1 reload, bit0 enable
   typedef struct packed {
      logic             one_shot;
      logic [PRE_W-1:0] pre_exp;
      logic [SRC_W-1:0] src_sel;
      logic             reload;
      logic             run_en;
   } tmr_ctrl_t;

   localparam int CTRL_W = $bits(tmr_ctrl_t);

   localparam tmr_ctrl_t CTRL_RST = '{one_shot: 1'b0, pre_exp: '0, src_sel: 2'd1,
                                      reload: 1'b0, run_en: 1'b0};

   // register select inside a channel block, from addr[3:2]
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_IVAL = 2'd1,
      REG_CNT  = 2'd2,
      REG_NONE = 2'd3
   } tmr_reg_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
   import tmr_bank_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int EXP_W   = PRE_W,
   localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int PH_W   = (EXP_W > 0) ? ((1 << EXP_W) - 1) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SEL_W-1:0]   src_sel,
   input  logic [EXP_W-1:0]   pre_exp,
   input  logic               run,
   input  logic               restart,
   output logic               tick_o
);

   logic sel_pulse;
   assign sel_pulse = src_tick[src_sel];

   generate
      if (EXP_W == 0) begin : g_nodiv
         assign tick_o = run && sel_pulse && !restart;
      end else begin : g_div
         logic [PH_W-1:0] phase;
         logic [PH_W-1:0] last;

         assign last   = PH_W'((32'd1 << pre_exp) - 32'd1);
         assign tick_o = run && sel_pulse && !restart && (phase == last);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase <= '0;
            end else if (restart || !run) begin
               phase <= '0;
            end else if (sel_pulse) begin
               phase <= (phase == last) ? '0 : phase + PH_W'(1);
            end
         end

         // R6: the phase never runs past the divide limit of the current exponent
         p_phase_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !restart) |-> (phase <= last));
      end
   endgenerate

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_bank_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic               ctrl_we,
   input  logic               ival_we,
   input  logic [DATA_W-1:0]  wdata,
   output tmr_ctrl_t          ctrl_o,
   output logic [DATA_W-1:0]  ival_o,
   output logic [DATA_W-1:0]  count_o,
   output logic               expire_o
);

   tmr_ctrl_t         ctrl;
   logic [DATA_W-1:0] ival;
   logic [DATA_W-1:0] count;
   logic              tick;
   tmr_ctrl_t         ctrl_wr;

   assign ctrl_wr = tmr_ctrl_t'(wdata[CTRL_W-1:0]);

   tmr_prescaler #(
      .NUM_SRC (NUM_SRC),
      .EXP_W   (PRE_W)
   ) i_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .src_sel  (ctrl.src_sel),
      .pre_exp  (ctrl.pre_exp),
      .run      (ctrl.run_en),
      .restart  (ctrl_we),
      .tick_o   (tick)
   );

   assign expire_o = tick && (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= CTRL_RST;
         ival  <= '0;
         count <= '0;
      end else begin
         if (ctrl_we) begin
            ctrl <= ctrl_wr;
            if (ctrl_wr.reload) begin
               count <= ival;
            end
         end else if (tick) begin
            if (count == '0) begin
               if (ctrl.one_shot) begin
                  ctrl.run_en <= 1'b0;
               end else begin
                  count <= ival;
               end
            end else begin
               count <= count - DATA_W'(1);
            end
         end
         if (ival_we) begin
            ival <= wdata;
         end
      end
   end

   assign ctrl_o  = ctrl;
   assign ival_o  = ival;
   assign count_o = count;

   // R6: a prescaled tick on a nonzero count steps it down by one
   p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (count != '0)) |=> (count == $past(count) - DATA_W'(1)));

   // R8: one-shot expiry leaves the channel disabled
   p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && ctrl.one_shot) |=> !ctrl.run_en);

   // R11: a disabled channel without a control write keeps its count
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.run_en && !ctrl_we) |=> $stable(count));

endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs #(
   parameter int NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ien_we,
   input  logic              sts_we,
   input  logic [NUM_CH-1:0] wdata,
   input  logic [NUM_CH-1:0] expire,
   output logic [NUM_CH-1:0] ien_o,
   output logic [NUM_CH-1:0] sts_o,
   output logic [NUM_CH-1:0] irq_o
);

   logic [NUM_CH-1:0] ien;
   logic [NUM_CH-1:0] sts;
   logic [NUM_CH-1:0] clr_mask;

   assign clr_mask = sts_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien <= '0;
         sts <= '0;
      end else begin
         if (ien_we) begin
            ien <= wdata;
         end
         sts <= (sts & ~clr_mask) | expire;
      end
   end

   assign ien_o = ien;
   assign sts_o = sts;
   assign irq_o = sts & ien;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
         // R10: an expiry always lands in status, even against a clear
         p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            expire[c] |=> sts[c]);
         // R10: a one written to status clears the bit when no event arrives
         p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_we && wdata[c] && !expire[c]) |=> !sts[c]);
      end
   endgenerate

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_bank_pkg::*;
#(
   parameter int NUM_CH  = 6,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 10,
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic [NUM_SRC-1:0] src_tick,
   output logic [NUM_CH-1:0]  irq
);

   localparam logic [3:0] OFS_IEN = 4'h0;
   localparam logic [3:0] OFS_STS = 4'h4;
   localparam int         PAD_CH  = DATA_W - NUM_CH;
   localparam int         PAD_CT  = DATA_W - CTRL_W;

   // elaboration checks on the parameter set
   generate
      if (NUM_CH < 1 || NUM_CH > 15) begin : g_bad_ch
         $error("tmr_bank: NUM_CH must lie in 1..15");
      end
      if (NUM_CH > DATA_W || CTRL_W > DATA_W) begin : g_bad_w
         $error("tmr_bank: DATA_W too narrow for the register contents");
      end
      if (ADDR_W < 9) begin : g_bad_a
         $error("tmr_bank: ADDR_W must be at least 9");
      end
      if (NUM_SRC != (1 << SRC_W)) begin : g_bad_src
         $error("tmr_bank: NUM_SRC must match the source-select field");
      end
   endgenerate

   // ---------------- address decode ----------------
   logic       upper_zero;
   logic [3:0] blk;
   logic [3:0] ch_idx;
   tmr_reg_e   sub;
   logic       ien_hit;
   logic       sts_hit;
   logic       ch_hit;
   logic       any_hit;

   assign upper_zero = (addr[ADDR_W-1:8] == '0);
   assign blk        = addr[7:4];
   assign ch_idx     = blk - 4'd1;
   assign sub        = tmr_reg_e'(addr[3:2]);
   assign ien_hit    = upper_zero && (blk == 4'd0) && (addr[3:0] == OFS_IEN);
   assign sts_hit    = upper_zero && (blk == 4'd0) && (addr[3:0] == OFS_STS);
   assign ch_hit     = upper_zero && (blk != 4'd0) && (32'(blk) <= NUM_CH)
                       && (addr[1:0] == 2'b00) && (sub != REG_NONE);
   assign any_hit    = ien_hit || sts_hit || ch_hit;

   // ---------------- channels ----------------
   tmr_ctrl_t         ctrl_a  [NUM_CH];
   logic [DATA_W-1:0] ival_a  [NUM_CH];
   logic [DATA_W-1:0] cnt_a   [NUM_CH];
   logic [NUM_CH-1:0] expire;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic sel_ch;
         assign sel_ch = wr_en && ch_hit && (ch_idx == 4'(c));

         tmr_channel #(
            .DATA_W  (DATA_W),
            .NUM_SRC (NUM_SRC)
         ) i_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (src_tick),
            .ctrl_we  (sel_ch && (sub == REG_CTRL)),
            .ival_we  (sel_ch && (sub == REG_IVAL)),
            .wdata    (wdata),
            .ctrl_o   (ctrl_a[c]),
            .ival_o   (ival_a[c]),
            .count_o  (cnt_a[c]),
            .expire_o (expire[c])
         );
      end
   endgenerate

   // ---------------- interrupt registers ----------------
   logic [NUM_CH-1:0] ien;
   logic [NUM_CH-1:0] sts;

   tmr_irq_regs #(
      .NUM_CH (NUM_CH)
   ) i_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .ien_we (wr_en && ien_hit),
      .sts_we (wr_en && sts_hit),
      .wdata  (wdata[NUM_CH-1:0]),
      .expire (expire),
      .ien_o  (ien),
      .sts_o  (sts),
      .irq_o  (irq)
   );

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (ien_hit) begin
         rd_val = {{PAD_CH{1'b0}}, ien};
      end else if (sts_hit) begin
         rd_val = {{PAD_CH{1'b0}}, sts};
      end else if (ch_hit) begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == 4'(c)) begin
               case (sub)
                  REG_CTRL: rd_val = {{PAD_CT{1'b0}}, ctrl_a[c]};
                  REG_IVAL: rd_val = ival_a[c];
                  REG_CNT:  rd_val = cnt_a[c];
                  default:  rd_val = '0;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         rdata <= rd_en ? rd_val : '0;
      end
   end

   // R3: a read of an undefined offset returns zero in the next cycle
   p_undef_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !any_hit) |=> (rdata == '0));

endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  src_tick = '0;
   logic [5:0]  irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_q = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   tmr_bank i_tmr_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .src_tick (src_tick),
      .irq      (irq)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: compares read data in the cycle after the strobe
   always @(posedge clk) rd_q <= rd_en;

   always @(negedge clk) begin
      if (rd_q) begin
         if (exp_q.size() == 0) begin
            check("scoreboard underflow", 32'd1, 32'd0);
         end else begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   task automatic wr(logic [9:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [9:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tk(int s, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         src_tick[s] = 1'b1;
         @(negedge clk);
         src_tick = '0;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check("watchdog", 32'd1, 32'd0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R2 map
      check("R1 irq after reset", 32'(irq), 32'd0);
      rd(10'h000, 32'h0, "R1 ien reset");
      rd(10'h004, 32'h0, "R1 status reset");
      rd(10'h010, 32'h4, "R1 ctrl0 reset");
      rd(10'h014, 32'h0, "R1 ival0 reset");
      rd(10'h018, 32'h0, "R1 count0 reset");
      rd(10'h060, 32'h4, "R2 ctrl5 reset");

      // channel 0: periodic, source 0, exponent 0, reload 5
      wr(10'h014, 32'd5);
      wr(10'h018, 32'h55);
      rd(10'h018, 32'd0, "R3 count is read-only");
      rd(10'h014, 32'd5, "R2 ival0 readback");
      wr(10'h010, 32'h03);
      rd(10'h018, 32'd5, "R4 reload on control write");
      tk(1, 3);
      rd(10'h018, 32'd5, "R5 unselected source ignored");
      tk(0, 2);
      rd(10'h018, 32'd3, "R5 selected source counts");
      tk(0, 3);
      rd(10'h018, 32'd0, "R7 count reaches zero");
      rd(10'h004, 32'd0, "R7 no expiry before zero tick");
      tk(0, 1);
      rd(10'h004, 32'd1, "R7 status set on expiry");
      rd(10'h018, 32'd5, "R7 periodic reload");
      @(negedge clk);
      check("R9 irq masked", 32'(irq), 32'd0);
      wr(10'h000, 32'd1);
      check("R9 irq enabled", 32'(irq), 32'd1);
      wr(10'h004, 32'd0);
      rd(10'h004, 32'd1, "R10 zero write keeps status");
      wr(10'h004, 32'd1);
      rd(10'h004, 32'd0, "R10 one write clears status");
      check("R9 irq after clear", 32'(irq), 32'd0);

      // R11 disable holds count
      wr(10'h010, 32'h00);
      tk(0, 2);
      rd(10'h018, 32'd5, "R11 disabled holds count");

      // channel 1: source 2, exponent 2 (divide by 4), reload 3
      wr(10'h024, 32'd3);
      wr(10'h020, 32'h2B);
      rd(10'h028, 32'd3, "R6 ch1 preload");
      tk(2, 3);
      rd(10'h028, 32'd3, "R6 no step before 4 pulses");
      tk(2, 1);
      rd(10'h028, 32'd2, "R6 step on 4th pulse");
      tk(2, 4);
      rd(10'h028, 32'd1, "R6 step on 8th pulse");
      tk(2, 2);
      wr(10'h020, 32'h29);
      tk(2, 3);
      rd(10'h028, 32'd1, "R6 control write restarts division");
      tk(2, 1);
      rd(10'h028, 32'd0, "R6 step after restart");

      // channel 2: one-shot, source 0, reload 1
      wr(10'h034, 32'd1);
      wr(10'h030, 32'h83);
      rd(10'h038, 32'd1, "R8 ch2 preload");
      tk(0, 1);
      rd(10'h038, 32'd0, "R8 ch2 at zero");
      tk(0, 1);
      rd(10'h030, 32'h82, "R8 enable bit cleared");
      rd(10'h004, 32'h4, "R8 status bit 2 set");
      rd(10'h038, 32'd0, "R8 count stays zero");
      wr(10'h004, 32'h4);
      tk(0, 3);
      rd(10'h004, 32'h0, "R8 no further expiry");

      // channel 3: periodic, reload 0, source 3: expiry against a clear
      wr(10'h044, 32'd0);
      wr(10'h040, 32'h0F);
      @(negedge clk);
      src_tick[3] = 1'b1;
      wr_en = 1'b1; addr = 10'h004; wdata = 32'h8;
      @(negedge clk);
      src_tick = '0; wr_en = 1'b0;
      rd(10'h004, 32'h8, "R10 set wins over clear");
      wr(10'h004, 32'h8);
      rd(10'h004, 32'h0, "R10 clear without event");

      // R3 undefined offsets
      wr(10'h008, 32'hFFFF_FFFF);
      rd(10'h008, 32'h0, "R3 offset 0x08 reads zero");
      wr(10'h070, 32'hFF);
      rd(10'h070, 32'h0, "R3 missing channel reads zero");
      rd(10'h01C, 32'h0, "R3 sub-offset 0xC reads zero");
      wr(10'h110, 32'hFF);
      rd(10'h110, 32'h0, "R3 high address reads zero");
      rd(10'h010, 32'h0, "R3 high address write ignored");
      rd(10'h000, 32'h1, "R2 ien readback");

      @(negedge clk);
      @(negedge clk);
      if (exp_q.size() != 0) check("scoreboard leftover", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule